// File: doc/BRIEF.md
# Serial receiver with idle-line wake-up

This block is the receive half of a small asynchronous serial port. An external rate generator gives it one `bitTick` pulse per bit time. On each tick it takes one sample of the receive line. It finds a low start bit, gathers eight data bits least significant first, checks the stop bit, and moves the finished byte into a data register that software can read. A byte-wide register port gives access to one control/status register and the data register. An interrupt output tells software that a byte is waiting or that an error has happened.

Overrun and framing errors share one error flag. A standby mode lets a listener skip traffic that is not meant for it. While standby is on, the receiver ignores frames and counts consecutive high samples. After ten such samples in a row the line counts as idle, standby turns itself off, and normal reception starts again.

Top module: `sci_rx_wake`

## Requirements
- R1: While `regSel`=0, `regRdata` shows the status byte: bit 7 full, bit 6 error, bit 4 interrupt enable, bit 3 receiver enable, bit 0 standby, and the other bits read 0. While `regSel`=1, it shows the data register. The read path is combinational. Every bit is 0 after reset.
- R2: A write with `regSel`=0 changes only bits 0, 3 and 4 of the status byte. The full and error flags ignore writes. A write with `regSel`=1 has no effect.
- R3: While the receiver enable bit is 0, ticks change no flag and no data.
- R4: When the receiver is idle, a low sample is taken as a start bit. A high sample keeps the receiver idle.
- R5: The eight samples after the start bit are data, least significant bit first.
- R6: A high stop sample with the full flag clear loads the byte into the data register and sets the full flag.
- R7: A high stop sample with the full flag already set is an overrun. It sets the error flag, keeps the old byte, and leaves the full flag set.
- R8: A low stop sample is a framing error. It sets the error flag, clears the full flag, and leaves the data register unchanged.
- R9: After the stop sample the receiver is idle again, so a start bit on the very next tick is accepted.
- R10: Writing a new value to the standby bit restarts the receiver's counting. While standby is on, frames are not received. Each high sample adds one to a run count and a low sample resets it. The tenth consecutive high sample clears the standby bit.
- R11: A status read while full or error is set, followed later by a data read, clears both flags from the next cycle. A data read that has no such status read before it clears nothing.
- R12: `irq` is high exactly when the interrupt enable bit is set and either the full flag or the error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One pulse per bit time: sample the line this cycle |
| rxLine | input | 1 | Serial receive line, idle high |
| regSel | input | 1 | 0 selects the status register, 1 selects the data register |
| regRd | input | 1 | Read strobe, used for the flag-clearing sequence |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rxLine` is stable around each tick and that the status flags change only because of a tick or a register access. Several properties also assume that register writes do not land on a tick cycle, because a write and a tick in the same cycle are resolved by priority and the properties do not model that. The stimulus keeps to these assumptions. Every tick lasts exactly one cycle and is followed by a cycle with no tick. All reads and writes happen in cycles with no tick. The line changes only at the falling clock edge.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
  localparam int REG_W   = 8;
  localparam int ST_WU   = 0;
  localparam int ST_RE   = 3;
  localparam int ST_RIE  = 4;
  localparam int ST_ERR  = 6;
  localparam int ST_FULL = 7;
  localparam logic [REG_W-1:0] ST_WR_MASK =
    REG_W'((1 << ST_WU) | (1 << ST_RE) | (1 << ST_RIE));

  typedef struct packed {
    logic startBit;
    logic shiftBit;
    logic stopOk;
    logic stopBad;
    logic wakeDone;
  } rxStrobe_t;
endpackage

// File: rtl/sci_rx_ctrl.sv
module sci_rx_ctrl
  import sci_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int WAKE_BITS = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      rxLine,
  input  logic      rxEn,
  input  logic      wakeMode,
  input  logic      wakeArm,
  output rxStrobe_t strobe
);
  localparam int STOP_POS = DATA_BITS + 1;
  localparam int MAXV     = (STOP_POS > WAKE_BITS) ? STOP_POS : WAKE_BITS;
  localparam int CNT_W    = $clog2(MAXV + 1);

  logic [CNT_W-1:0] bitCnt, cntNext;

  always_comb begin
    strobe  = '0;
    cntNext = bitCnt;
    if (wakeArm) begin
      cntNext = '0;
    end else if (bitTick && rxEn) begin
      if (wakeMode) begin
        if (rxLine) begin
          if (bitCnt == CNT_W'(WAKE_BITS - 1)) begin
            strobe.wakeDone = 1'b1;
            cntNext = '0;
          end else begin
            cntNext = bitCnt + CNT_W'(1);
          end
        end else begin
          cntNext = '0;
        end
      end else if (bitCnt == '0) begin
        if (!rxLine) begin
          strobe.startBit = 1'b1;
          cntNext = CNT_W'(1);
        end
      end else if (bitCnt == CNT_W'(STOP_POS)) begin
        strobe.stopOk  = rxLine;
        strobe.stopBad = !rxLine;
        cntNext = '0;
      end else begin
        strobe.shiftBit = 1'b1;
        cntNext = bitCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else       bitCnt <= cntNext;
  end
endmodule

// File: rtl/sci_rx_dp.sv
module sci_rx_dp
  import sci_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 rxLine,
  input  logic                 regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic                 irq,
  output logic                 rxEn,
  output logic                 wuQ,
  output logic                 rieQ,
  output logic                 wakeArm,
  output logic                 fullQ,
  output logic                 errQ,
  output logic [DATA_BITS-1:0] rdrQ
);
  logic [REG_W-1:0]     ctlQ, ctlNext;
  logic [DATA_BITS-1:0] shiftQ;
  logic                 armQ, fullNext, errNext, armNext;
  logic                 statusWr, clearNow;

  assign statusWr = regWr && !regSel;
  assign clearNow = regRd && regSel && armQ;
  assign wuQ      = ctlQ[ST_WU];
  assign rxEn     = ctlQ[ST_RE];
  assign rieQ     = ctlQ[ST_RIE];
  assign wakeArm  = statusWr && (regWdata[ST_WU] != wuQ);

  always_comb begin
    ctlNext = ctlQ;
    if (statusWr)             ctlNext = regWdata & ST_WR_MASK;
    else if (strobe.wakeDone) ctlNext[ST_WU] = 1'b0;

    fullNext = fullQ;
    errNext  = errQ;
    if (clearNow) begin
      fullNext = 1'b0;
      errNext  = 1'b0;
    end
    if (strobe.stopOk && !fullQ) fullNext = 1'b1;
    if (strobe.stopOk && fullQ)  errNext  = 1'b1;
    if (strobe.stopBad) begin
      errNext  = 1'b1;
      fullNext = 1'b0;
    end

    armNext = armQ;
    if (regRd && !regSel && (fullQ || errQ)) armNext = 1'b1;
    else if (regRd && regSel)                armNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ   <= '0;
      fullQ  <= 1'b0;
      errQ   <= 1'b0;
      armQ   <= 1'b0;
      shiftQ <= '0;
      rdrQ   <= '0;
    end else begin
      ctlQ  <= ctlNext;
      fullQ <= fullNext;
      errQ  <= errNext;
      armQ  <= armNext;
      if (strobe.startBit)      shiftQ <= '0;
      else if (strobe.shiftBit) shiftQ <= {rxLine, shiftQ[DATA_BITS-1:1]};
      if (strobe.stopOk && !fullQ) rdrQ <= shiftQ;
    end
  end

  always_comb begin
    if (regSel) begin
      regRdata = REG_W'(rdrQ);
    end else begin
      regRdata = ctlQ;
      regRdata[ST_FULL] = fullQ;
      regRdata[ST_ERR]  = errQ;
    end
  end

  assign irq = rieQ && (fullQ || errQ);
endmodule

// File: rtl/sci_rx_wake.sv
module sci_rx_wake
  import sci_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int WAKE_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       rxLine,
  input  logic       regSel,
  input  logic       regRd,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq
);
  rxStrobe_t            strobe;
  logic                 rxEn, wuQ, rieQ, wakeArm, fullQ, errQ;
  logic [DATA_BITS-1:0] rdrQ;

  sci_rx_ctrl #(.DATA_BITS(DATA_BITS), .WAKE_BITS(WAKE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
    .rxEn(rxEn), .wakeMode(wuQ), .wakeArm(wakeArm), .strobe(strobe)
  );

  sci_rx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLine(rxLine),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .rxEn(rxEn), .wuQ(wuQ), .rieQ(rieQ),
    .wakeArm(wakeArm), .fullQ(fullQ), .errQ(errQ), .rdrQ(rdrQ)
  );
endmodule

// File: rtl/sci_rx_wake_chk.sv
module sci_rx_wake_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 bitTick,
  input logic                 rxLine,
  input logic                 regWr,
  input logic                 irq,
  input logic                 rxEn,
  input logic                 wuQ,
  input logic                 rieQ,
  input logic                 fullQ,
  input logic                 errQ,
  input logic [DATA_BITS-1:0] rdrQ
);
  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> ($stable(rdrQ) && !$rose(fullQ) && !$rose(errQ)));

  // R6
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdrQ) |-> fullQ);

  // R6
  full_from_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullQ) |-> ($past(bitTick) && $past(rxLine)));

  // R8
  error_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $stable(rdrQ));

  // R10
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wuQ) |-> ($past(regWr) || ($past(bitTick) && $past(rxLine))));

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rieQ |-> !irq);

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (fullQ || errQ));
endmodule

bind sci_rx_wake sci_rx_wake_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
  .regWr(regWr), .irq(irq), .rxEn(rxEn), .wuQ(wuQ), .rieQ(rieQ),
  .fullQ(fullQ), .errQ(errQ), .rdrQ(rdrQ)
);

// File: tb/tb_sci_rx_wake.sv
`timescale 1ns/1ps
module tb_sci_rx_wake;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       regSel = 1'b0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sci_rx_wake dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  // behavioural reference
  int mWu, mRe, mRie, mFull, mErr, mArm, mRdr, mIdleRun, mInFrame;
  bit mBits[$];
  int nWu, nRe, nRie, nFull, nErr, nArm, clr, sw, flip, val;

  always @(posedge clk) begin
    if (!rstN) begin
      mWu = 0; mRe = 0; mRie = 0; mFull = 0; mErr = 0; mArm = 0;
      mRdr = 0; mIdleRun = 0; mInFrame = 0; mBits.delete();
    end else begin
      nWu = mWu; nRe = mRe; nRie = mRie; nFull = mFull; nErr = mErr; nArm = mArm;
      clr  = (regRd && regSel && mArm != 0) ? 1 : 0;
      sw   = (regWr && !regSel) ? 1 : 0;
      flip = (sw != 0 && int'(regWdata[0]) != mWu) ? 1 : 0;
      if (regRd && !regSel && (mFull != 0 || mErr != 0)) nArm = 1;
      else if (regRd && regSel) nArm = 0;
      if (clr != 0) begin nFull = 0; nErr = 0; end
      if (flip != 0) begin
        mIdleRun = 0; mInFrame = 0; mBits.delete();
      end else if (bitTick && mRe != 0) begin
        if (mWu != 0) begin
          if (rxLine) begin
            mIdleRun++;
            if (mIdleRun == 10) begin nWu = 0; mIdleRun = 0; end
          end else mIdleRun = 0;
        end else if (mInFrame == 0) begin
          if (!rxLine) begin mInFrame = 1; mBits.delete(); end
        end else if (mBits.size() < 8) begin
          mBits.push_back(rxLine);
        end else begin
          val = 0;
          foreach (mBits[i]) val |= int'(mBits[i]) << i;
          if (rxLine) begin
            if (mFull != 0) nErr = 1;
            else begin mRdr = val; nFull = 1; end
          end else begin
            nErr = 1; nFull = 0;
          end
          mInFrame = 0; mBits.delete();
        end
      end
      if (sw != 0) begin
        nWu = int'(regWdata[0]); nRe = int'(regWdata[3]); nRie = int'(regWdata[4]);
      end
      mWu = nWu; mRe = nRe; mRie = nRie; mFull = nFull; mErr = nErr; mArm = nArm;
    end
  end

  function automatic logic [7:0] modelRead(input logic sel);
    if (sel) return mRdr[7:0];
    return {mFull[0], mErr[0], 1'b0, mRie[0], mRe[0], 2'b00, mWu[0]};
  endfunction

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      checks++;
      if (regRdata !== modelRead(regSel)) begin
        errors++;
        $display("FAIL R1 cycle compare regRdata act %h exp %h", regRdata, modelRead(regSel));
      end
      checks++;
      if (irq !== (mRie != 0 && (mFull != 0 || mErr != 0))) begin
        errors++;
        $display("FAIL R12 cycle compare irq act %b exp %b", irq,
                 (mRie != 0 && (mFull != 0 || mErr != 0)));
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); rxLine = b; bitTick = 1'b1;
    @(negedge clk); bitTick = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic stopV);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(stopV);
    rxLine = 1'b1;
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] v);
    @(negedge clk); regSel = sel; regWr = 1'b1; regWdata = v;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] v);
    @(negedge clk); regSel = sel; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(1'b0, v); chk("R1 reset status", v, 8'h00);
    readReg(1'b1, v); chk("R1 reset data", v, 8'h00);
    chk("R12 reset irq", {7'b0, irq}, 8'h00);

    // R2 write masking and ignored data write
    writeReg(1'b0, 8'hFF);
    readReg(1'b0, v); chk("R2 status write mask", v, 8'h19);
    writeReg(1'b0, 8'h08);
    writeReg(1'b1, 8'hFF);
    readReg(1'b1, v); chk("R2 data write ignored", v, 8'h00);

    // R4 high samples keep receiver idle, then R5/R6 frame
    sendBit(1'b1); sendBit(1'b1);
    readReg(1'b0, v); chk("R4 idle on high", v, 8'h08);
    sendFrame(8'hA5, 1'b1);
    readReg(1'b1, v); chk("R5 data LSB first", v, 8'hA5);
    readReg(1'b0, v); chk("R6 full after stop / R11 data read alone", v, 8'h88);
    chk("R12 irq masked", {7'b0, irq}, 8'h00);

    // R7 overrun
    sendFrame(8'h3C, 1'b1);
    readReg(1'b0, v); chk("R7 overrun status", v, 8'hC8);
    readReg(1'b1, v); chk("R7 old byte kept", v, 8'hA5);
    readReg(1'b0, v); chk("R11 flags cleared", v, 8'h08);

    // R8 framing with interrupt enabled
    writeReg(1'b0, 8'h18);
    sendFrame(8'h5A, 1'b0);
    readReg(1'b0, v); chk("R8 framing status", v, 8'h58);
    chk("R12 irq on error", {7'b0, irq}, 8'h01);
    readReg(1'b1, v); chk("R8 data unchanged", v, 8'hA5);
    readReg(1'b0, v); chk("R11 error cleared", v, 8'h18);
    chk("R12 irq dropped", {7'b0, irq}, 8'h00);

    // R9 back-to-back frames, clearing between them
    sendFrame(8'h0F, 1'b1);
    chk("R12 irq on full", {7'b0, irq}, 8'h01);
    readReg(1'b0, v);
    readReg(1'b1, v); chk("R9 first frame", v, 8'h0F);
    sendFrame(8'hF0, 1'b1);
    readReg(1'b1, v); chk("R9 second frame", v, 8'hF0);
    readReg(1'b0, v); chk("R9 full again", v, 8'h98);
    readReg(1'b1, v);

    // R3 disabled receiver ignores a frame
    writeReg(1'b0, 8'h00);
    sendFrame(8'h77, 1'b1);
    readReg(1'b0, v); chk("R3 disabled status", v, 8'h00);
    readReg(1'b1, v); chk("R3 disabled data", v, 8'hF0);

    // R10 wake-up standby
    writeReg(1'b0, 8'h09);
    for (int i = 0; i < 9; i++) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 0; i < 9; i++) sendBit(1'b1);
    readReg(1'b0, v); chk("R10 still in standby", v, 8'h09);
    sendBit(1'b1);
    readReg(1'b0, v); chk("R10 standby cleared", v, 8'h08);
    sendFrame(8'h33, 1'b1);
    readReg(1'b1, v); chk("R10 reception resumed", v, 8'h33);
    readReg(1'b0, v); chk("R10 full after resume", v, 8'h88);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule